// File: doc/BRIEF.md
# Two-Step Subranging Result Assembler

This block is the digital back end of an 8-bit half-flash converter. A single bank of 15 comparators is used twice in each conversion. In the coarse pass the bank compares the selected input against the reference ladder. In the fine pass it compares the residue that remains after the upper nibble has been subtracted by a residue DAC. The block reduces each 15-bit thermometer word to a 4-bit nibble. It drives the coarse nibble to the DAC for the fine pass. It then assembles the 8-bit straight-binary result in an output register.

A conversion begins on a rising edge of the start strobe, which also samples the 3-bit channel address. The upper nibble is committed, and becomes visible on the result port, when the strobe drops. The lower nibble follows after a fixed number of DAC settling cycles, together with a one-cycle end-of-conversion pulse. The highest channel address is tied internally to the upper reference and always converts to all ones. One LSB is the reference span divided by 256.

Top module: `subrange_assembler`

## Requirements
- R1: While reset is asserted and at its release, result_o is 0x00, eoc_o, busy_o and fine_o are 0, and dac_code_o is 0.
- R2: In idle, a rising edge of start_i captures addr_i. From the next cycle busy_o is 1, and mux_sel_o holds the captured address unchanged until the conversion ends.
- R3: Each pass reduces the thermometer word to the count of its ones (0 to 15). A word that is not monotonic still gives its count of ones as the nibble.
- R4: On the first clock edge in the coarse phase at which start_i is 0, the coarse nibble is written to result_o[7:4] and result_o[3:0] is cleared. On that same edge fine_o rises and dac_code_o takes the coarse nibble.
- R5: SETTLE_CYC clock edges after the coarse latch, the fine nibble is written to result_o[3:0], while result_o[7:4] keeps the coarse nibble.
- R6: eoc_o is 1 for exactly one cycle, the first cycle in which the complete 8-bit word is on result_o. busy_o and fine_o are 0 in that cycle.
- R7: Address 7 selects the channel tied to the upper reference. Its conversion yields 0xFF whatever the comparator bank reports.
- R8: A rising edge of start_i while busy_o is 1 is ignored. The current conversion completes with its own address and result, and no new conversion follows.
- R9: Between conversions, result_o holds the last word while the comparator inputs change.
- R10: With ideal comparators and DAC, an input of v LSB above the lower reference (0 to 255) converts to result v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion strobe; rising edge starts, falling edge commits the coarse nibble |
| addr_i | input | 3 | Channel address, sampled on the start edge |
| therm_i | input | 15 | Thermometer word from the shared comparator bank |
| mux_sel_o | output | 3 | Channel select to the analog multiplexer |
| fine_o | output | 1 | 1 while the bank compares the residue |
| dac_code_o | output | 4 | Code to the residue DAC |
| result_o | output | 8 | Assembled conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench sweeps every input level on every real channel. It supplies the other channels with a mirrored level, so a multiplexer or nibble-order fault shows up as a wrong code rather than a lucky match. A DAC that is not fed the coarse nibble makes the residue, and so the low nibble, wrong across whole bands of codes. The bench repeats the sweep with bubbles injected into the thermometer words; an encoder that looks for the top one instead of counting ones returns codes that are off by one at every bubble. It drives the full-scale channel with an all-zero bank output, retriggers the strobe in the middle of the fine phase, and checks that the upper nibble is visible with a cleared lower nibble before the end pulse. Each of these catches a design that lets the comparators override the tied channel, restarts on a busy strobe, or commits both nibbles at once.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_e;
endpackage

// File: rtl/sr_therm_enc.sv
module sr_therm_enc #(
  parameter int NIB_W = 4,
  localparam int THERM_W = (1 << NIB_W) - 1
) (
  input  logic [THERM_W-1:0] therm_i,
  output logic [NIB_W-1:0]   code_o
);
  // ones count: bubble-tolerant, always a legal code
  logic [NIB_W:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < THERM_W; i++) acc = acc + {{NIB_W{1'b0}}, therm_i[i]};
    code_o = acc[NIB_W-1:0];
  end
endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import subrange_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int SETTLE_CYC = 2,
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] chan_o,
  output logic              latch_msb_o,
  output logic              latch_lsb_o,
  output logic              busy_o,
  output logic              fine_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  phase_e            ph_q;
  logic              start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] chan_q;
  logic              start_rise;

  assign start_rise = start_i & ~start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      chan_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_rise) begin
          ph_q   <= PH_COARSE;
          chan_q <= addr_i;
        end
        PH_COARSE: if (!start_i) begin
          ph_q  <= PH_FINE;
          cnt_q <= '0;
        end
        PH_FINE: begin
          if (cnt_q == LAST) ph_q <= PH_IDLE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign chan_o      = chan_q;
  assign latch_msb_o = (ph_q == PH_COARSE) && !start_i;
  assign latch_lsb_o = (ph_q == PH_FINE) && (cnt_q == LAST);
  assign busy_o      = (ph_q != PH_IDLE);
  assign fine_o      = (ph_q == PH_FINE);
endmodule

// File: rtl/sr_result.sv
module sr_result #(
  parameter int NIB_W   = 4,
  parameter int ADDR_W  = 3,
  parameter int FS_CHAN = (1 << ADDR_W) - 1,
  localparam int RES_W  = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_msb_i,
  input  logic              latch_lsb_i,
  input  logic [NIB_W-1:0]  code_i,
  input  logic [ADDR_W-1:0] chan_i,
  output logic [RES_W-1:0]  result_o,
  output logic [NIB_W-1:0]  dac_o,
  output logic              eoc_o
);
  logic [RES_W-1:0] res_q;
  logic [NIB_W-1:0] dac_q;
  logic             eoc_q;
  logic [NIB_W-1:0] nib;

  // tied channel reads the upper reference in both passes
  assign nib = (chan_i == ADDR_W'(FS_CHAN)) ? {NIB_W{1'b1}} : code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      dac_q <= '0;
      eoc_q <= 1'b0;
    end else begin
      eoc_q <= latch_lsb_i;
      if (latch_msb_i) begin
        res_q <= {nib, {NIB_W{1'b0}}};
        dac_q <= nib;
      end else if (latch_lsb_i) begin
        res_q[NIB_W-1:0] <= nib;
      end
    end
  end

  assign result_o = res_q;
  assign dac_o    = dac_q;
  assign eoc_o    = eoc_q;
endmodule

// File: rtl/subrange_assembler.sv
module subrange_assembler #(
  parameter int NIB_W      = 4,
  parameter int ADDR_W     = 3,
  parameter int SETTLE_CYC = 2,
  parameter int FS_CHAN    = (1 << ADDR_W) - 1,
  localparam int THERM_W   = (1 << NIB_W) - 1,
  localparam int RES_W     = 2 * NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [THERM_W-1:0] therm_i,
  output logic [ADDR_W-1:0]  mux_sel_o,
  output logic               fine_o,
  output logic [NIB_W-1:0]   dac_code_o,
  output logic [RES_W-1:0]   result_o,
  output logic               eoc_o,
  output logic               busy_o
);
  logic [NIB_W-1:0]  code;
  logic [ADDR_W-1:0] chan;
  logic              latch_msb, latch_lsb;

  sr_therm_enc #(.NIB_W(NIB_W)) u_enc (
    .therm_i (therm_i),
    .code_o  (code)
  );

  sr_seq #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .chan_o      (chan),
    .latch_msb_o (latch_msb),
    .latch_lsb_o (latch_lsb),
    .busy_o      (busy_o),
    .fine_o      (fine_o)
  );

  sr_result #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .FS_CHAN(FS_CHAN)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_msb_i (latch_msb),
    .latch_lsb_i (latch_lsb),
    .code_i      (code),
    .chan_i      (chan),
    .result_o    (result_o),
    .dac_o       (dac_code_o),
    .eoc_o       (eoc_o)
  );

  assign mux_sel_o = chan;
endmodule

// File: rtl/subrange_assembler_chk.sv
module subrange_assembler_chk #(
  parameter int NIB_W   = 4,
  parameter int ADDR_W  = 3,
  parameter int FS_CHAN = (1 << ADDR_W) - 1,
  localparam int RES_W  = 2 * NIB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] mux_sel_o,
  input logic              fine_o,
  input logic [NIB_W-1:0]  dac_code_o,
  input logic [RES_W-1:0]  result_o,
  input logic              eoc_o,
  input logic              busy_o
);
  logic start_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_d <= 1'b0;
    else         start_d <= start_i;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !start_d && !busy_o) |=> busy_o); // R2
  AST_MUX_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mux_sel_o)); // R2
  AST_DAC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_o |-> (dac_code_o == result_o[RES_W-1:NIB_W])); // R4
  AST_LOW_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fine_o) |-> (result_o[NIB_W-1:0] == '0)); // R4
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o); // R6
  AST_EOC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> (!busy_o && !fine_o)); // R6
  AST_FS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && mux_sel_o == ADDR_W'(FS_CHAN)) |-> (result_o == '1)); // R7
endmodule

bind subrange_assembler subrange_assembler_chk #(
  .NIB_W(NIB_W), .ADDR_W(ADDR_W), .FS_CHAN(FS_CHAN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mux_sel_o  (mux_sel_o),
  .fine_o     (fine_o),
  .dac_code_o (dac_code_o),
  .result_o   (result_o),
  .eoc_o      (eoc_o),
  .busy_o     (busy_o)
);

// File: tb/subrange_assembler_tb.sv
module subrange_assembler_tb;
  localparam int SETTLE = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  addr = '0;
  logic [14:0] therm;
  logic [2:0]  mux_sel;
  logic        fine;
  logic [3:0]  dac;
  logic [7:0]  result;
  logic        eoc, busy;

  int vin [7];
  bit bubble = 1'b0;
  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  subrange_assembler #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .addr_i(addr),
    .therm_i(therm), .mux_sel_o(mux_sel), .fine_o(fine),
    .dac_code_o(dac), .result_o(result), .eoc_o(eoc), .busy_o(busy)
  );

  // ideal comparator bank + residue DAC
  always_comb begin
    int v, n;
    logic [15:0] w;
    if (mux_sel == 3'd7) therm = '0;
    else begin
      v = vin[mux_sel];
      if (!fine) n = v / 16;
      else       n = v - 16 * int'(dac);
      if (n < 0)  n = 0;
      if (n > 15) n = 15;
      w = (16'h1 << n) - 16'h1;
      if (bubble && n > 0 && n < 15) begin
        w[n-1] = 1'b0;
        w[n]   = 1'b1;
      end
      therm = w[14:0];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int ch, input int expv, input bit retrig);
    @(negedge clk); start = 1'b1; addr = 3'(ch);
    @(negedge clk); start = 1'b0; addr = 3'(ch + 1);
    check(busy == 1'b1, "R2 busy", int'(busy), 1);
    check(mux_sel == 3'(ch), "R2 mux", int'(mux_sel), ch);
    @(negedge clk);
    check(result[7:4] == 4'(expv >> 4), "R4 msb", int'(result[7:4]), expv >> 4);
    check(result[3:0] == 4'h0, "R4 lsb cleared", int'(result[3:0]), 0);
    check(fine && dac == 4'(expv >> 4), "R4 dac", int'(dac), expv >> 4);
    if (retrig) begin start = 1'b1; addr = 3'((ch + 3) % 7); end
    for (int i = 0; i < SETTLE; i++) begin
      if (i == SETTLE - 1) check(eoc == 1'b0, "R5 no early eoc", int'(eoc), 0);
      @(negedge clk); start = 1'b0;
    end
    check(result == 8'(expv), "R10 R5 result", int'(result), expv);
    check(eoc && !busy, "R6 eoc", int'(eoc), 1);
    @(negedge clk);
    check(eoc == 1'b0, "R6 eoc one cycle", int'(eoc), 0);
    if (retrig) begin
      check(busy == 1'b0, "R8 no restart", int'(busy), 0);
      check(mux_sel == 3'(ch), "R8 addr kept", int'(mux_sel), ch);
      check(result == 8'(expv), "R8 result kept", int'(result), expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 7; c++) vin[c] = 0;
    repeat (3) @(negedge clk);
    check(result == 8'h00 && !eoc && !busy && !fine && dac == 4'h0, "R1 in reset", int'(result), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(result == 8'h00 && !eoc && !busy && !fine && dac == 4'h0, "R1 after reset", int'(result), 0);

    // R10: every level on every real channel, neighbours mirrored
    for (int c = 0; c < 7; c++)
      for (int v = 0; v < 256; v++) begin
        for (int k = 0; k < 7; k++) vin[k] = 255 - v;
        vin[c] = v;
        convert(c, v, 1'b0);
      end

    // R3: bubbled thermometer words
    bubble = 1'b1;
    for (int v = 0; v < 256; v++) begin
      vin[2] = v;
      convert(2, v, 1'b0);
    end
    bubble = 1'b0;

    // R7: tied channel with an all-zero comparator bank
    for (int v = 0; v < 4; v++) convert(7, 255, 1'b0);

    // R8: strobe during the fine phase
    vin[4] = 77; vin[0] = 200; vin[1] = 13;
    convert(4, 77, 1'b1);
    convert(7, 255, 1'b1);

    // R9: result holds while inputs change
    vin[5] = 141;
    convert(5, 141, 1'b0);
    for (int i = 0; i < 6; i++) begin
      vin[5] = i * 40;
      @(negedge clk);
      check(result == 8'd141 && !busy, "R9 hold", int'(result), 141);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule